// File: doc/BRIEF.md
# Oversampling SPI Slave Interface

This block is the receive-and-transmit engine of an SPI slave that lives wholly in the system clock domain. The external SCK, MOSI and slave-select pins are brought into the system clock through synchronizers. Edges of SCK are then found by comparing successive synchronized samples, so no logic is clocked by SCK itself. While slave-select is high, the engine is parked. The MISO output enable is low, and the host may write the byte to be sent. While slave-select is low, every detected sample edge captures one MOSI bit and every detected shift edge advances the transmit register. Both registers work most significant bit first.

When a whole byte has been sampled, it is copied into a holding register that the host reads. A completion flag is raised, and so is an interrupt if it is enabled. The host may preload the next byte to send before it reads the received one. A byte that completes while the previous one is still unread sets a sticky overrun flag and replaces the older byte. Clock polarity and phase are selectable, which gives the four usual sampling modes.

Top module: `spiSlaveOvs`

## Requirements
- R1: While `ssN` is high, `misoOe` is 0. SCK edges that arrive while `ssN` is high change neither the received data, the flags nor the bit position of the next transfer.
- R2: A byte written through `txWrEn`/`txWrData` while `ssN` is high is presented on `misoOut` most significant bit first during the next transfer. With `cpha`=0, bit 7 is already on `misoOut` before the first SCK edge.
- R3: Bits are captured from MOSI most significant bit first. With `cpha`=0 capture is on the leading SCK edge; with `cpha`=1 it is on the trailing edge. The leading edge is rising when `cpol`=0 and falling when `cpol`=1. After eight captures the byte appears on `rxData`.
- R4: The completion flag `doneFlag` is set when the eighth bit is captured and cleared by a one-cycle `rxRdEn` pulse. A completion in the same cycle as a read wins over the read. `irq` equals `doneFlag` AND `irqEn`.
- R5: A byte written while a transfer is running does not disturb the current byte. It is sent as the following byte when `ssN` stays low.
- R6: When a byte completes while `doneFlag` is still set and no read occurs in that cycle, `overrunFlag` is set and the new byte replaces the old one in `rxData`. `overrunFlag` stays set until an `rxRdEn` pulse clears it. `rxData` changes only when a byte completes.
- R7: If `ssN` rises before eight bits have been captured, the partial byte is dropped without setting `doneFlag`. The next transfer starts again at bit 7.
- R8: Reception works with SCK at one quarter of the system clock rate, that is with two system clocks per SCK phase.
- R9: SCK, MOSI and `ssN` pass through two-stage synchronizers. `misoOe` equals the inverse of `ssN` as it was sampled two rising clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Idle level of SCK (selects the leading edge) |
| cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| irqEn | input | 1 | Enables `irq` from the completion flag |
| txWrEn | input | 1 | Write strobe for the transmit byte |
| txWrData | input | DATA_W | Byte to transmit |
| rxRdEn | input | 1 | Read strobe; clears completion and overrun flags |
| rxData | output | DATA_W | Last completed received byte |
| doneFlag | output | 1 | Byte-complete flag |
| overrunFlag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | SPI clock pin |
| mosiIn | input | 1 | Master-out data pin |
| ssN | input | 1 | Slave-select pin, active low |
| misoOut | output | 1 | Slave-out data value |
| misoOe | output | 1 | Output enable for the MISO pad |

## Verification
The bench builds the block with its defaults: an 8-bit word and two synchronizer stages. The default word width lets the bit counter wrap on its own power-of-two boundary. The two stages fix the pin-to-action latency at three clocks, so every output can be predicted cycle by cycle. That latency is what makes the quarter-rate receive case (R8) and the exact `misoOe` timing (R9) observable. It also explains why the transmit path is checked at one eighth of the clock rate, where the data-out delay still fits inside an SCK phase.

// File: rtl/spi_ovs_pkg.sv
package spi_ovs_pkg;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic idle;     // slave-select inactive: park and preload
    logic sample;   // capture one MOSI bit
    logic shift;    // advance the transmit register
    logic lastBit;  // this capture completes the word
    logic loadTx;   // this shift edge starts a new word: load from txReg
  } spiStrobes_t;

endpackage

// File: rtl/spiSyncStage.sv
module spiSyncStage #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spiSlaveCtrl.sv
module spiSlaveCtrl
  import spi_ovs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpol,
  input  logic        cpha,
  input  logic        sckIn,
  input  logic        mosiIn,
  input  logic        ssN,
  output logic        mosiBit,
  output spiStrobes_t stb
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic sckS, ssS, sckQ;
  logic rise, fall, leadEdge, trailEdge, active, sampleE, shiftE;
  logic [CNT_W-1:0] bitCnt;

  // Three pins, same depth, so MOSI stays aligned to SCK
  spiSyncStage #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSyncSck (
    .clk(clk), .rstN(rstN), .d(sckIn), .q(sckS));
  spiSyncStage #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSyncMosi (
    .clk(clk), .rstN(rstN), .d(mosiIn), .q(mosiBit));
  spiSyncStage #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSyncSs (
    .clk(clk), .rstN(rstN), .d(ssN), .q(ssS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckQ <= 1'b0;
    else       sckQ <= sckS;
  end

  assign rise      = sckS & ~sckQ;
  assign fall      = ~sckS & sckQ;
  assign leadEdge  = cpol ? fall : rise;
  assign trailEdge = cpol ? rise : fall;
  assign active    = ~ssS;
  assign sampleE   = active & (cpha ? trailEdge : leadEdge);
  assign shiftE    = active & (cpha ? leadEdge : trailEdge);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitCnt <= '0;
    else if (!active)   bitCnt <= '0;
    else if (sampleE)   bitCnt <= (bitCnt == LAST_IDX) ? '0 : bitCnt + CNT_W'(1);
  end

  always_comb begin
    stb.idle    = ~active;
    stb.sample  = sampleE;
    stb.shift   = shiftE;
    stb.lastBit = sampleE & (bitCnt == LAST_IDX);
    stb.loadTx  = shiftE & (bitCnt == '0);
  end

  // R7: a deselect always leaves the next word starting at its first bit
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssS) |=> !stb.lastBit && (bitCnt == '0));

  // R3: capture and shift never happen in the same cycle
  assert_edges_apart_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.sample && stb.shift));

endmodule

// File: rtl/spiSlaveData.sv
module spiSlaveData
  import spi_ovs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       stb,
  input  logic              mosiBit,
  input  logic              irqEn,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              overrunFlag,
  output logic              irq,
  output logic              misoBit
);

  logic [DATA_W-1:0] txReg, txShift, rxShift, rxHold, nextWord;

  assign nextWord = {rxShift[DATA_W-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       txReg <= '0;
    else if (txWrEn) txReg <= txWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           txShift <= '0;
    else if (stb.idle)   txShift <= txReg;
    else if (stb.loadTx) txShift <= txReg;
    else if (stb.shift)  txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxShift <= '0;
    else if (stb.sample) rxShift <= nextWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold      <= '0;
      doneFlag    <= 1'b0;
      overrunFlag <= 1'b0;
    end else if (stb.lastBit) begin
      rxHold      <= nextWord;
      doneFlag    <= 1'b1;
      overrunFlag <= (overrunFlag | doneFlag) & ~rxRdEn;
    end else if (rxRdEn) begin
      doneFlag    <= 1'b0;
      overrunFlag <= 1'b0;
    end
  end

  assign rxData  = rxHold;
  assign irq     = doneFlag & irqEn;
  assign misoBit = txShift[DATA_W-1];

  // R4: a completing capture always leaves the flag set
  assert_done_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.lastBit |=> doneFlag);

  // R6: an unread word overtaken by a new one raises overrun
  assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lastBit && doneFlag && !rxRdEn) |=> overrunFlag);

  // R6: overrun is sticky until read
  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !rxRdEn) |=> overrunFlag);

  // R6: the received word moves only on completion
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.lastBit |=> $stable(rxData));

endmodule

// File: rtl/spiSlaveOvs.sv
module spiSlaveOvs
  import spi_ovs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              irqEn,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              overrunFlag,
  output logic              irq,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssN,
  output logic              misoOut,
  output logic              misoOe
);

  spiStrobes_t stb;
  logic        mosiBit;

  spiSlaveCtrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha),
    .sckIn(sckIn), .mosiIn(mosiIn), .ssN(ssN),
    .mosiBit(mosiBit), .stb(stb));

  spiSlaveData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiBit(mosiBit), .irqEn(irqEn),
    .txWrEn(txWrEn), .txWrData(txWrData), .rxRdEn(rxRdEn),
    .rxData(rxData), .doneFlag(doneFlag), .overrunFlag(overrunFlag),
    .irq(irq), .misoBit(misoOut));

  assign misoOe = ~stb.idle;

  // R9/R1: the pad enable follows the select pin after the synchronizer delay
  assert_oe_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 1) && $past(rstN, 2) && SYNC_STAGES == 2) |-> (misoOe == !$past(ssN, 2)));

endmodule

// File: tb/tb_spiSlaveOvs.sv
`timescale 1ns/1ps
module tb_spiSlaveOvs;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, irqEn = 1'b0;
  logic txWrEn = 1'b0, rxRdEn = 1'b0;
  logic [W-1:0] txWrData = '0;
  logic [W-1:0] rxData;
  logic doneFlag, overrunFlag, irq, misoOut, misoOe;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssN = 1'b1;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  spiSlaveOvs #(.DATA_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .irqEn(irqEn),
    .txWrEn(txWrEn), .txWrData(txWrData), .rxRdEn(rxRdEn),
    .rxData(rxData), .doneFlag(doneFlag), .overrunFlag(overrunFlag),
    .irq(irq), .sckIn(sckIn), .mosiIn(mosiIn), .ssN(ssN),
    .misoOut(misoOut), .misoOe(misoOe));

  task automatic check(input logic [31:0] actual, input logic [31:0] expected, input string tag);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic pS1, pS2, mS1, mS2, sS1, sS2, pPrev;
  int   mCnt;
  logic [W-1:0] mRx, mTxSh, mTxReg, mHold, nb, oldTx;
  logic mDone, mOvr;
  bit   act, rise, fall, lead, trail, smp, shf;
  int   oldCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      pS1 = 0; pS2 = 0; mS1 = 0; mS2 = 0; sS1 = 1; sS2 = 1; pPrev = 0;
      mCnt = 0; mRx = '0; mTxSh = '0; mTxReg = '0; mHold = '0; mDone = 0; mOvr = 0;
    end else begin
      act   = !sS2;
      rise  = pS2 && !pPrev;
      fall  = !pS2 && pPrev;
      lead  = cpol ? fall : rise;
      trail = cpol ? rise : fall;
      smp   = act && (cpha ? trail : lead);
      shf   = act && (cpha ? lead : trail);
      nb    = {mRx[W-2:0], mS2};
      oldTx = mTxReg;
      oldCnt = mCnt;
      if (smp && oldCnt == W-1) begin
        mOvr  = (mOvr | mDone) & !rxRdEn;
        mDone = 1;
        mHold = nb;
      end else if (rxRdEn) begin
        mDone = 0;
        mOvr  = 0;
      end
      if (smp) mRx = nb;
      if (!act) mCnt = 0;
      else if (smp) mCnt = (oldCnt == W-1) ? 0 : oldCnt + 1;
      if (!act) mTxSh = oldTx;
      else if (shf) mTxSh = (oldCnt == 0) ? oldTx : {mTxSh[W-2:0], 1'b0};
      if (txWrEn) mTxReg = txWrData;
      pPrev = pS2; pS2 = pS1; pS1 = sckIn;
      mS2 = mS1; mS1 = mosiIn;
      sS2 = sS1; sS1 = ssN;
    end
  end

  // compare the design against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN) begin
      check(rxData, mHold, "R3 rxData vs model");
      check(doneFlag, mDone, "R4 doneFlag vs model");
      check(irq, mDone & irqEn, "R4 irq vs model");
      check(overrunFlag, mOvr, "R6 overrunFlag vs model");
      check(misoOe, !sS2, "R9 misoOe vs model");
      if (misoOe) check(misoOut, mTxSh[W-1], "R2 misoOut vs model");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTx(input logic [W-1:0] v);
    txWrData = v; txWrEn = 1'b1; waitc(1); txWrEn = 1'b0;
  endtask

  task automatic readRx();
    rxRdEn = 1'b1; waitc(1); rxRdEn = 1'b0;
  endtask

  task automatic setMode(input logic pol, input logic pha);
    cpol = pol; cpha = pha; sckIn = pol; waitc(6);
  endtask

  // master side: nbits clocks, half = system clocks per SCK phase
  task automatic xfer(input logic [W-1:0] mb, input int nbits, input int half, output logic [W-1:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosiIn = mb[W-1-i]; waitc(half);
        got[W-1-i] = misoOut; sckIn = ~sckIn; waitc(half);
        sckIn = ~sckIn;
      end else begin
        waitc(half); sckIn = ~sckIn; mosiIn = mb[W-1-i]; waitc(half);
        got[W-1-i] = misoOut; sckIn = ~sckIn;
      end
    end
    waitc(6);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [W-1:0] got, got2;
    waitc(5);
    rstN = 1'b1;
    waitc(2);
    check(doneFlag, 0, "R4 reset doneFlag");
    check(overrunFlag, 0, "R6 reset overrunFlag");
    check(misoOe, 0, "R1 reset misoOe");
    check(rxData, 0, "R3 reset rxData");

    // R9: exact enable timing after select falls
    ssN = 1'b0; waitc(1);
    check(misoOe, 0, "R9 misoOe one clock after select");
    waitc(1);
    check(misoOe, 1, "R9 misoOe two clocks after select");
    ssN = 1'b1; waitc(4);

    // R2/R3/R4: all four modes
    for (int m = 0; m < 4; m++) begin
      logic [W-1:0] txv, rxv;
      txv = 8'hA5 ^ W'(m * 37);
      rxv = 8'h3C + W'(m * 51);
      setMode(m[1], m[0]);
      irqEn = m[0];
      writeTx(txv);
      ssN = 1'b0; waitc(6);
      xfer(rxv, W, 4, got);
      check(rxData, rxv, $sformatf("R3 received byte mode %0d", m));
      check(got, txv, $sformatf("R2 transmitted byte mode %0d", m));
      check(doneFlag, 1, "R4 done after eighth bit");
      check(irq, m[0], "R4 irq gated by irqEn");
      readRx(); waitc(1);
      check(doneFlag, 0, "R4 done cleared by read");
      ssN = 1'b1; waitc(4);
      check(misoOe, 0, "R1 enable low after deselect");
    end

    // R1: SCK while deselected is ignored
    setMode(1'b0, 1'b0);
    mosiIn = 1'b1;
    for (int k = 0; k < 16; k++) begin sckIn = ~sckIn; waitc(4); end
    waitc(4);
    check(doneFlag, 0, "R1 no completion while deselected");
    check(misoOe, 0, "R1 enable stays low while deselected");
    check(rxData, 8'h3C + 8'(3 * 51), "R1 rxData untouched while deselected");
    ssN = 1'b0; waitc(6);
    xfer(8'h3C, W, 4, got);
    check(rxData, 8'h3C, "R1 bit position not advanced by ignored clocks");
    readRx(); ssN = 1'b1; waitc(4);

    // R5/R6: back-to-back bytes, next tx written mid-transfer, no read between
    writeTx(8'h11);
    ssN = 1'b0; waitc(6);
    writeTx(8'h22);
    xfer(8'h81, W, 4, got);
    check(got, 8'h11, "R5 first byte unchanged by mid-transfer write");
    check(rxData, 8'h81, "R3 first received byte");
    check(overrunFlag, 0, "R6 no overrun yet");
    xfer(8'h42, W, 4, got2);
    check(got2, 8'h22, "R5 preloaded byte sent next");
    check(overrunFlag, 1, "R6 overrun on unread byte");
    check(rxData, 8'h42, "R6 newer byte replaces older");
    waitc(8);
    check(overrunFlag, 1, "R6 overrun sticky");
    readRx(); waitc(1);
    check(overrunFlag, 0, "R6 overrun cleared by read");
    check(doneFlag, 0, "R4 done cleared with overrun");
    ssN = 1'b1; waitc(4);

    // R7: partial byte dropped on deselect
    setMode(1'b0, 1'b1);
    ssN = 1'b0; waitc(6);
    xfer(8'hE0, 3, 4, got);
    ssN = 1'b1; waitc(6);
    check(doneFlag, 0, "R7 partial byte sets no flag");
    check(rxData, 8'h42, "R7 partial byte not stored");
    ssN = 1'b0; waitc(6);
    xfer(8'hC3, W, 4, got);
    check(rxData, 8'hC3, "R7 next byte realigned");
    readRx(); ssN = 1'b1; waitc(4);

    // R8: quarter-rate receive
    setMode(1'b0, 1'b0);
    ssN = 1'b0; waitc(6);
    xfer(8'h96, W, 2, got);
    check(rxData, 8'h96, "R8 receive at clk/4");
    check(doneFlag, 1, "R8 done at clk/4");
    readRx(); ssN = 1'b1; waitc(6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule